// File: doc/BRIEF.md
# Reorder Buffer with Precise Exceptions

This block keeps in-flight instructions in program order for a pipeline that dispatches in order and lets functional units finish out of order. Each decoded instruction claims the next slot of a circular buffer and takes back a slot number, its tag. A functional unit later reports completion against that tag with a result, an optional store address and an exception flag.

Each cycle, only the oldest slot may leave the buffer. If that slot has finished cleanly, its result is written either to the register-file port or to the memory port. If it finished with an exception, the block does three things in that same cycle: it reports the faulting PC, it drives a fetch redirect to a fixed handler address, and it discards every slot. Slots that have not finished hold back everything behind them, so architectural state only ever reflects an in-order prefix of the program.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer is empty. `alloc_id` is 0, and `alloc_full`, `rf_we`, `mem_we` and `exc_flush` are all low.
- R2: Each accepted allocation returns the current tail slot on `alloc_id`, and the tail then advances by one modulo DEPTH. After DEPTH allocations with no retirement, `alloc_full` is high. While `alloc_full` is high, a request on `alloc_valid` is refused and leaves the buffer unchanged.
- R3: A completion updates a slot only if that slot is allocated and not yet completed. A completion that names a free slot is ignored, even if that slot is allocated later.
- R4: Retirement is in order, at most one slot per cycle. A completed younger slot waits until every older slot has retired. An incomplete oldest slot produces no retire action.
- R5: When the oldest slot is a completed non-store without an exception, `rf_we` is high for one cycle. In that cycle `rf_addr` is the slot's destination register and `rf_data` is the completed value.
- R6: When the oldest slot is a completed store (`alloc_store`=1) without an exception, `mem_we` is high for one cycle. In that cycle `mem_addr` is the completed `cmpl_addr` and `mem_data` is the completed value.
- R7: When the oldest slot has completed with `cmpl_exc`=1, `exc_flush` is high for one cycle. In that cycle `exc_pc` is the slot's PC, `redirect_pc` is the HANDLER_PC parameter, and neither `rf_we` nor `mem_we` is asserted.
- R8: A flush empties the buffer in one cycle. In the next cycle `alloc_id` equals the faulting slot's index, `alloc_full` is low, and no younger slot retires, including slots that had already completed.
- R9: An exception on a slot that is not the oldest has no effect until that slot becomes the oldest. Older slots retire normally before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset, already synchronized to clk on release |
| alloc_valid | input | 1 | Decode requests a slot |
| alloc_pc | input | XLEN | PC of the instruction being allocated |
| alloc_dest | input | REG_W | Destination register of the instruction |
| alloc_store | input | 1 | 1 = store, retires to memory; 0 = retires to the register file |
| alloc_id | output | log2(DEPTH) | Slot that an allocation made this cycle receives |
| alloc_full | output | 1 | Buffer holds DEPTH slots; allocation is refused |
| cmpl_valid | input | 1 | A functional unit reports completion |
| cmpl_id | input | log2(DEPTH) | Slot being completed |
| cmpl_value | input | XLEN | Result value, or store data for a store |
| cmpl_addr | input | XLEN | Store address (used by stores only) |
| cmpl_exc | input | 1 | Instruction raised an exception |
| rf_we | output | 1 | Register-file write strobe |
| rf_addr | output | REG_W | Register-file write index |
| rf_data | output | XLEN | Register-file write data |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | XLEN | Memory write address |
| mem_data | output | XLEN | Memory write data |
| exc_flush | output | 1 | Oldest slot faulted; all slots discarded |
| exc_pc | output | XLEN | PC of the faulting instruction |
| redirect_pc | output | XLEN | Fetch target for the exception handler |

## Verification
Some properties are checked by assertions on every cycle, using the head and tail pointers:
- the occupancy never exceeds DEPTH;
- a refused allocation leaves the tail where it was;
- at most one of register write, memory write and flush fires in a cycle;
- every write moves the head by exactly one;
- nothing retires from an empty buffer;
- the cycle after a flush shows an empty, non-full buffer with no commit.

Other behaviour depends on the data and on the order of events, so only the bench's scenarios can show it:
- the written registers, addresses and values match the slots retired, in program order;
- a younger completion does not overtake an older one;
- a stray completion to a free slot is ignored;
- the faulting PC and handler address are reported correctly;
- already-finished younger work is discarded after a fault.

// File: rtl/rob_pkg.sv
package rob_pkg;

  // What the oldest slot does this cycle
  typedef enum logic [1:0] {
    RET_IDLE  = 2'd0,
    RET_REG   = 2'd1,
    RET_MEM   = 2'd2,
    RET_FAULT = 2'd3
  } ret_act_e;

endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned PTR_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic             flush,
  output logic [PTR_W-1:0] head_ptr,
  output logic [PTR_W-1:0] tail_ptr,
  output logic             full,
  output logic             empty
);

  logic [PTR_W-1:0] head_q, head_n;
  logic [PTR_W-1:0] tail_q, tail_n;

  always_comb begin
    head_n = head_q;
    tail_n = tail_q;
    if (flush) begin
      tail_n = head_q;
    end else begin
      if (push) tail_n = tail_q + PTR_W'(1);
      if (pop)  head_n = head_q + PTR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      head_q <= head_n;
      tail_q <= tail_n;
    end
  end

  assign head_ptr = head_q;
  assign tail_ptr = tail_q;
  assign empty    = (head_q == tail_q);
  assign full     = (head_q[IDX_W-1:0] == tail_q[IDX_W-1:0]) &&
                    (head_q[IDX_W] != tail_q[IDX_W]);

endmodule

// File: rtl/rob_slots.sv
module rob_slots #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned XLEN  = 32,
  parameter int unsigned REG_W = 5,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_en,
  input  logic [IDX_W-1:0] alloc_idx,
  input  logic [XLEN-1:0]  alloc_pc,
  input  logic [REG_W-1:0] alloc_dest,
  input  logic             alloc_store,
  input  logic             cmpl_en,
  input  logic [IDX_W-1:0] cmpl_idx,
  input  logic [XLEN-1:0]  cmpl_value,
  input  logic [XLEN-1:0]  cmpl_addr,
  input  logic             cmpl_exc,
  input  logic             pop_en,
  input  logic             flush,
  input  logic [IDX_W-1:0] head_idx,
  output logic             hd_valid,
  output logic             hd_done,
  output logic             hd_exc,
  output logic             hd_store,
  output logic [REG_W-1:0] hd_dest,
  output logic [XLEN-1:0]  hd_pc,
  output logic [XLEN-1:0]  hd_value,
  output logic [XLEN-1:0]  hd_addr
);

  // Status bits carry a reset; payload is written only under an enable
  logic [DEPTH-1:0] valid_q, valid_n;
  logic [DEPTH-1:0] done_q,  done_n;
  logic [DEPTH-1:0] exc_q,   exc_n;
  logic [DEPTH-1:0] alloc_hit, cmpl_hit, pop_hit;

  logic             store_q [DEPTH];
  logic [REG_W-1:0] dest_q  [DEPTH];
  logic [XLEN-1:0]  pc_q    [DEPTH];
  logic [XLEN-1:0]  value_q [DEPTH];
  logic [XLEN-1:0]  addr_q  [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_hit
    assign alloc_hit[g] = alloc_en && (alloc_idx == IDX_W'(g));
    assign pop_hit[g]   = pop_en && (head_idx == IDX_W'(g));
    assign cmpl_hit[g]  = cmpl_en && (cmpl_idx == IDX_W'(g)) &&
                          valid_q[g] && !done_q[g] && !flush;
  end

  always_comb begin
    valid_n = valid_q;
    done_n  = done_q;
    exc_n   = exc_q;
    for (int i = 0; i < DEPTH; i++) begin
      if (flush) begin
        valid_n[i] = 1'b0;
        done_n[i]  = 1'b0;
        exc_n[i]   = 1'b0;
      end else begin
        if (pop_hit[i]) begin
          valid_n[i] = 1'b0;
          done_n[i]  = 1'b0;
          exc_n[i]   = 1'b0;
        end
        if (alloc_hit[i]) begin
          valid_n[i] = 1'b1;
          done_n[i]  = 1'b0;
          exc_n[i]   = 1'b0;
        end
        if (cmpl_hit[i]) begin
          done_n[i] = 1'b1;
          exc_n[i]  = cmpl_exc;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      done_q  <= '0;
      exc_q   <= '0;
    end else begin
      valid_q <= valid_n;
      done_q  <= done_n;
      exc_q   <= exc_n;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (alloc_hit[i]) begin
        store_q[i] <= alloc_store;
        dest_q[i]  <= alloc_dest;
        pc_q[i]    <= alloc_pc;
      end
      if (cmpl_hit[i]) begin
        value_q[i] <= cmpl_value;
        addr_q[i]  <= cmpl_addr;
      end
    end
  end

  assign hd_valid = valid_q[head_idx];
  assign hd_done  = done_q[head_idx];
  assign hd_exc   = exc_q[head_idx];
  assign hd_store = store_q[head_idx];
  assign hd_dest  = dest_q[head_idx];
  assign hd_pc    = pc_q[head_idx];
  assign hd_value = value_q[head_idx];
  assign hd_addr  = addr_q[head_idx];

endmodule

// File: rtl/rob_retire.sv
module rob_retire
  import rob_pkg::*;
#(
  parameter int unsigned     XLEN       = 32,
  parameter int unsigned     REG_W      = 5,
  parameter logic [XLEN-1:0] HANDLER_PC = '0
) (
  input  logic             hd_valid,
  input  logic             hd_done,
  input  logic             hd_exc,
  input  logic             hd_store,
  input  logic [REG_W-1:0] hd_dest,
  input  logic [XLEN-1:0]  hd_pc,
  input  logic [XLEN-1:0]  hd_value,
  input  logic [XLEN-1:0]  hd_addr,
  output ret_act_e         act,
  output logic             rf_we,
  output logic [REG_W-1:0] rf_addr,
  output logic [XLEN-1:0]  rf_data,
  output logic             mem_we,
  output logic [XLEN-1:0]  mem_addr,
  output logic [XLEN-1:0]  mem_data,
  output logic             exc_flush,
  output logic [XLEN-1:0]  exc_pc,
  output logic [XLEN-1:0]  redirect_pc
);

  always_comb begin
    if (!hd_valid || !hd_done) act = RET_IDLE;
    else if (hd_exc)           act = RET_FAULT;
    else if (hd_store)         act = RET_MEM;
    else                       act = RET_REG;
  end

  assign rf_we       = (act == RET_REG);
  assign rf_addr     = hd_dest;
  assign rf_data     = hd_value;
  assign mem_we      = (act == RET_MEM);
  assign mem_addr    = hd_addr;
  assign mem_data    = hd_value;
  assign exc_flush   = (act == RET_FAULT);
  assign exc_pc      = hd_pc;
  assign redirect_pc = HANDLER_PC;

endmodule

// File: rtl/rob_core.sv
module rob_core
  import rob_pkg::*;
#(
  parameter int unsigned     DEPTH      = 16,
  parameter int unsigned     XLEN       = 32,
  parameter int unsigned     REG_W      = 5,
  parameter logic [XLEN-1:0] HANDLER_PC = 32'h0000_0200,
  localparam int unsigned    IDX_W      = $clog2(DEPTH),
  localparam int unsigned    PTR_W      = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_valid,
  input  logic [XLEN-1:0]  alloc_pc,
  input  logic [REG_W-1:0] alloc_dest,
  input  logic             alloc_store,
  output logic [IDX_W-1:0] alloc_id,
  output logic             alloc_full,
  input  logic             cmpl_valid,
  input  logic [IDX_W-1:0] cmpl_id,
  input  logic [XLEN-1:0]  cmpl_value,
  input  logic [XLEN-1:0]  cmpl_addr,
  input  logic             cmpl_exc,
  output logic             rf_we,
  output logic [REG_W-1:0] rf_addr,
  output logic [XLEN-1:0]  rf_data,
  output logic             mem_we,
  output logic [XLEN-1:0]  mem_addr,
  output logic [XLEN-1:0]  mem_data,
  output logic             exc_flush,
  output logic [XLEN-1:0]  exc_pc,
  output logic [XLEN-1:0]  redirect_pc
);

  logic [PTR_W-1:0] head_ptr, tail_ptr;
  logic             full, empty;
  logic             push, pop;
  ret_act_e         act;

  logic             hd_valid, hd_done, hd_exc, hd_store;
  logic [REG_W-1:0] hd_dest;
  logic [XLEN-1:0]  hd_pc, hd_value, hd_addr;

  assign push       = alloc_valid && !full && !exc_flush;
  assign pop        = (act == RET_REG) || (act == RET_MEM);
  assign alloc_id   = tail_ptr[IDX_W-1:0];
  assign alloc_full = full;

  rob_ptrs #(.DEPTH(DEPTH)) i_ptrs (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push),
    .pop      (pop),
    .flush    (exc_flush),
    .head_ptr (head_ptr),
    .tail_ptr (tail_ptr),
    .full     (full),
    .empty    (empty)
  );

  rob_slots #(.DEPTH(DEPTH), .XLEN(XLEN), .REG_W(REG_W)) i_slots (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_en    (push),
    .alloc_idx   (tail_ptr[IDX_W-1:0]),
    .alloc_pc    (alloc_pc),
    .alloc_dest  (alloc_dest),
    .alloc_store (alloc_store),
    .cmpl_en     (cmpl_valid),
    .cmpl_idx    (cmpl_id),
    .cmpl_value  (cmpl_value),
    .cmpl_addr   (cmpl_addr),
    .cmpl_exc    (cmpl_exc),
    .pop_en      (pop),
    .flush       (exc_flush),
    .head_idx    (head_ptr[IDX_W-1:0]),
    .hd_valid    (hd_valid),
    .hd_done     (hd_done),
    .hd_exc      (hd_exc),
    .hd_store    (hd_store),
    .hd_dest     (hd_dest),
    .hd_pc       (hd_pc),
    .hd_value    (hd_value),
    .hd_addr     (hd_addr)
  );

  rob_retire #(.XLEN(XLEN), .REG_W(REG_W), .HANDLER_PC(HANDLER_PC)) i_retire (
    .hd_valid    (hd_valid),
    .hd_done     (hd_done),
    .hd_exc      (hd_exc),
    .hd_store    (hd_store),
    .hd_dest     (hd_dest),
    .hd_pc       (hd_pc),
    .hd_value    (hd_value),
    .hd_addr     (hd_addr),
    .act         (act),
    .rf_we       (rf_we),
    .rf_addr     (rf_addr),
    .rf_data     (rf_data),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_data    (mem_data),
    .exc_flush   (exc_flush),
    .exc_pc      (exc_pc),
    .redirect_pc (redirect_pc)
  );

  logic unused_empty;
  assign unused_empty = empty;

endmodule

// File: rtl/rob_core_chk.sv
module rob_core_chk #(
  parameter int unsigned  DEPTH = 16,
  localparam int unsigned PTR_W = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             alloc_valid,
  input logic             alloc_full,
  input logic             rf_we,
  input logic             mem_we,
  input logic             exc_flush,
  input logic [PTR_W-1:0] head_ptr,
  input logic [PTR_W-1:0] tail_ptr
);

  logic [PTR_W-1:0] occupancy;
  assign occupancy = tail_ptr - head_ptr;

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy <= PTR_W'(DEPTH));

  assert_full_refuses_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && alloc_full && !exc_flush) |=> $stable(tail_ptr));

  assert_single_action_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rf_we, mem_we, exc_flush}));

  assert_retire_advances_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we || mem_we) |=> (head_ptr == $past(head_ptr) + PTR_W'(1)));

  assert_empty_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (head_ptr == tail_ptr) |-> !(rf_we || mem_we || exc_flush));

  assert_no_commit_after_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
    exc_flush |=> !(rf_we || mem_we || exc_flush));

  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    exc_flush |=> ((head_ptr == tail_ptr) && !alloc_full));

endmodule

bind rob_core rob_core_chk #(.DEPTH(DEPTH)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .alloc_valid (alloc_valid),
  .alloc_full  (alloc_full),
  .rf_we       (rf_we),
  .mem_we      (mem_we),
  .exc_flush   (exc_flush),
  .head_ptr    (head_ptr),
  .tail_ptr    (tail_ptr)
);

// File: tb/test_rob_core.sv
module test_rob_core;

  localparam int unsigned DEPTH   = 4;
  localparam int unsigned XLEN    = 32;
  localparam int unsigned REG_W   = 5;
  localparam int unsigned IDX_W   = $clog2(DEPTH);
  localparam logic [31:0] HANDLER = 32'h0000_0100;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             alloc_valid, alloc_store;
  logic [XLEN-1:0]  alloc_pc;
  logic [REG_W-1:0] alloc_dest;
  logic [IDX_W-1:0] alloc_id;
  logic             alloc_full;
  logic             cmpl_valid, cmpl_exc;
  logic [IDX_W-1:0] cmpl_id;
  logic [XLEN-1:0]  cmpl_value, cmpl_addr;
  logic             rf_we, mem_we, exc_flush;
  logic [REG_W-1:0] rf_addr;
  logic [XLEN-1:0]  rf_data, mem_addr, mem_data, exc_pc, redirect_pc;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  rob_core #(.DEPTH(DEPTH), .XLEN(XLEN), .REG_W(REG_W), .HANDLER_PC(HANDLER)) i_rob_core (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_pc(alloc_pc), .alloc_dest(alloc_dest),
    .alloc_store(alloc_store), .alloc_id(alloc_id), .alloc_full(alloc_full),
    .cmpl_valid(cmpl_valid), .cmpl_id(cmpl_id), .cmpl_value(cmpl_value),
    .cmpl_addr(cmpl_addr), .cmpl_exc(cmpl_exc),
    .rf_we(rf_we), .rf_addr(rf_addr), .rf_data(rf_data),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data),
    .exc_flush(exc_flush), .exc_pc(exc_pc), .redirect_pc(redirect_pc)
  );

  // act code: 0 none, 1 register write, 2 memory write, 3 flush
  typedef struct packed {
    logic        av;
    logic        ast;
    logic [4:0]  adest;
    logic [31:0] apc;
    logic        cv;
    logic [1:0]  cid;
    logic [31:0] cval;
    logic [31:0] caddr;
    logic        cexc;
    logic [1:0]  exp_id;
    logic [1:0]  exp_act;
    logic [31:0] exp_addr;
    logic [31:0] exp_data;
  } vec_t;

  // Each row: expected outputs checked first, then the row's inputs applied
  localparam vec_t VECS [9] = '{
    '{1'b1, 1'b0, 5'd1, 32'h10, 1'b0, 2'd0, 32'h0,  32'h0,  1'b0, 2'd0, 2'd0, 32'h0,  32'h0},
    '{1'b1, 1'b1, 5'd0, 32'h14, 1'b0, 2'd0, 32'h0,  32'h0,  1'b0, 2'd1, 2'd0, 32'h0,  32'h0},
    '{1'b1, 1'b0, 5'd3, 32'h18, 1'b1, 2'd1, 32'hAA, 32'h40, 1'b0, 2'd2, 2'd0, 32'h0,  32'h0},
    '{1'b0, 1'b0, 5'd0, 32'h0,  1'b1, 2'd2, 32'hBB, 32'h0,  1'b0, 2'd3, 2'd0, 32'h0,  32'h0},
    '{1'b0, 1'b0, 5'd0, 32'h0,  1'b1, 2'd0, 32'h11, 32'h0,  1'b0, 2'd3, 2'd0, 32'h0,  32'h0},
    '{1'b0, 1'b0, 5'd0, 32'h0,  1'b0, 2'd0, 32'h0,  32'h0,  1'b0, 2'd3, 2'd1, 32'h1,  32'h11},
    '{1'b0, 1'b0, 5'd0, 32'h0,  1'b0, 2'd0, 32'h0,  32'h0,  1'b0, 2'd3, 2'd2, 32'h40, 32'hAA},
    '{1'b0, 1'b0, 5'd0, 32'h0,  1'b0, 2'd0, 32'h0,  32'h0,  1'b0, 2'd3, 2'd1, 32'h3,  32'hBB},
    '{1'b0, 1'b0, 5'd0, 32'h0,  1'b0, 2'd0, 32'h0,  32'h0,  1'b0, 2'd3, 2'd0, 32'h0,  32'h0}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [1:0] obs_act();
    if (exc_flush)   return 2'd3;
    else if (mem_we) return 2'd2;
    else if (rf_we)  return 2'd1;
    return 2'd0;
  endfunction

  task automatic idle();
    alloc_valid = 1'b0; alloc_store = 1'b0; alloc_pc = '0; alloc_dest = '0;
    cmpl_valid  = 1'b0; cmpl_id = '0; cmpl_value = '0; cmpl_addr = '0; cmpl_exc = 1'b0;
  endtask

  task automatic do_alloc(input logic st, input logic [4:0] dest, input logic [31:0] pc);
    idle();
    alloc_valid = 1'b1; alloc_store = st; alloc_dest = dest; alloc_pc = pc;
  endtask

  task automatic do_cmpl(input logic [1:0] id, input logic [31:0] val, input logic exc);
    idle();
    cmpl_valid = 1'b1; cmpl_id = id; cmpl_value = val; cmpl_exc = exc;
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle();
    rst_n = 1'b0;

    // R1 reset state
    do_reset();
    chk("R1 alloc_id", 32'(alloc_id), 32'd0);
    chk("R1 alloc_full", 32'(alloc_full), 32'd0);
    chk("R1 no action", 32'(obs_act()), 32'd0);

    // Vector walk: out-of-order completion, in-order retire (R2 R4 R5 R6)
    for (int i = 0; i < 9; i++) begin
      chk("R2 tag order", 32'(alloc_id), 32'(VECS[i].exp_id));
      chk("R4 retire action", 32'(obs_act()), 32'(VECS[i].exp_act));
      if (VECS[i].exp_act == 2'd1) begin
        chk("R5 rf_addr", 32'(rf_addr), VECS[i].exp_addr);
        chk("R5 rf_data", rf_data, VECS[i].exp_data);
      end else if (VECS[i].exp_act == 2'd2) begin
        chk("R6 mem_addr", mem_addr, VECS[i].exp_addr);
        chk("R6 mem_data", mem_data, VECS[i].exp_data);
      end
      idle();
      alloc_valid = VECS[i].av;   alloc_store = VECS[i].ast;
      alloc_dest  = VECS[i].adest; alloc_pc   = VECS[i].apc;
      cmpl_valid  = VECS[i].cv;   cmpl_id     = VECS[i].cid;
      cmpl_value  = VECS[i].cval; cmpl_addr   = VECS[i].caddr;
      cmpl_exc    = VECS[i].cexc;
      @(negedge clk);
    end

    // R2 fill to capacity, refused allocation, then drain
    do_reset();
    for (int k = 0; k < DEPTH; k++) begin
      chk("R2 tag while filling", 32'(alloc_id), 32'(k));
      do_alloc(1'b0, 5'(k + 8), 32'h200 + 32'(k));
      @(negedge clk);
    end
    chk("R2 full after DEPTH", 32'(alloc_full), 32'd1);
    do_alloc(1'b0, 5'd31, 32'h999);
    @(negedge clk);
    chk("R2 still full after refusal", 32'(alloc_full), 32'd1);
    chk("R2 tag unchanged after refusal", 32'(alloc_id), 32'd0);
    for (int k = 0; k < DEPTH; k++) begin
      do_cmpl(2'(k), 32'h50 + 32'(k), 1'b0);
      @(negedge clk);
      chk("R5 drain rf_we", 32'(rf_we), 32'd1);
      chk("R5 drain rf_addr", 32'(rf_addr), 32'(k + 8));
      chk("R5 drain rf_data", rf_data, 32'h50 + 32'(k));
    end
    idle();
    @(negedge clk);
    chk("R2 empty after drain", 32'(obs_act()), 32'd0);
    chk("R2 not full after drain", 32'(alloc_full), 32'd0);
    chk("R2 tag wrapped", 32'(alloc_id), 32'd0);

    // R3 completion to a free slot is ignored
    do_reset();
    do_cmpl(2'd2, 32'hDEAD, 1'b0);
    @(negedge clk);
    chk("R3 stray completion no action", 32'(obs_act()), 32'd0);
    for (int k = 0; k < 3; k++) begin
      do_alloc(1'b0, 5'(k + 1), 32'h300 + 32'(k));
      @(negedge clk);
    end
    do_cmpl(2'd0, 32'h1, 1'b0);
    @(negedge clk);
    chk("R5 rf_data slot0", rf_data, 32'h1);
    do_cmpl(2'd1, 32'h2, 1'b0);
    @(negedge clk);
    chk("R5 rf_data slot1", rf_data, 32'h2);
    idle();
    @(negedge clk);
    chk("R3 slot2 not completed by stray write", 32'(obs_act()), 32'd0);
    @(negedge clk);
    chk("R3 slot2 still waiting", 32'(obs_act()), 32'd0);

    // R7 R8 R9 exception on a younger slot, then at the head
    do_reset();
    do_alloc(1'b0, 5'd4, 32'h20); @(negedge clk);
    do_alloc(1'b0, 5'd5, 32'h24); @(negedge clk);
    do_alloc(1'b0, 5'd6, 32'h28); @(negedge clk);
    do_cmpl(2'd1, 32'hEE, 1'b1);  @(negedge clk);
    do_cmpl(2'd2, 32'hCC, 1'b0);  @(negedge clk);
    chk("R9 fault behind incomplete head waits", 32'(obs_act()), 32'd0);
    do_cmpl(2'd0, 32'hA0, 1'b0);  @(negedge clk);
    chk("R9 older slot retires first", 32'(obs_act()), 32'd1);
    chk("R9 older rf_addr", 32'(rf_addr), 32'd4);
    chk("R9 older rf_data", rf_data, 32'hA0);
    do_alloc(1'b0, 5'd9, 32'h44);
    @(negedge clk);
    chk("R7 flush raised", 32'(obs_act()), 32'd3);
    chk("R7 no rf write", 32'(rf_we), 32'd0);
    chk("R7 no mem write", 32'(mem_we), 32'd0);
    chk("R7 faulting pc", exc_pc, 32'h24);
    chk("R7 redirect target", redirect_pc, HANDLER);
    idle();
    @(negedge clk);
    chk("R8 younger completed slot discarded", 32'(obs_act()), 32'd0);
    chk("R8 tail back at fault slot", 32'(alloc_id), 32'd1);
    chk("R8 not full", 32'(alloc_full), 32'd0);
    @(negedge clk);
    chk("R8 still nothing retires", 32'(obs_act()), 32'd0);

    finish_run();
  end

endmodule